// File: doc/BRIEF.md
# USB PHY Power Sequencer

This block brings an on-chip USB PHY out of power-down and puts it back. A single-cycle power-on request releases the PHY reset, drops both power-down controls and turns the PHY PLL on in one step. The block then waits for the PHY to report a stable clock. The wait is bounded: if the clock-good indication does not arrive within a set number of timebase ticks, the sequence finishes anyway and a sticky timeout flag is raised, so software is never left hanging. A short settle period, also counted in ticks, follows before the ready flag is given.

A single-cycle power-off request turns the PLL off and asserts both power-down controls. It can arrive at any point, including during the clock wait or the settle period, and it aborts the sequence at once. The timebase tick is a clock-enable pulse from a slower free-running divider. Wait and settle lengths are parameters counted in those ticks. All pins are plain control and status signals; there is no data stream, so no valid/ready handshake applies.

Top module: `phy_pwr_seq`

## Requirements
- R1: After reset, phy_rst=1, phy_pd=1, otg_pd=1, pll_en=0, ready=0 and timed_out=0. phy_rst stays 1 until the first accepted power-on request and, once cleared, is never set again.
- R2: A power-on request while powered down (pll_en=0) makes phy_rst=0, phy_pd=0, otg_pd=0 and pll_en=1 together, one clock after the request cycle, and timed_out=0 from that same clock.
- R3: While waiting, a cycle with clk_good=1 ends the wait and starts the settle period; ready is never 1 unless clk_good was seen in the wait.
- R4: If clk_good has not been seen by the WAIT_TICKS-th tick of the wait, timed_out becomes 1 one clock after that tick, the sequence goes on with the controls left powered, and ready stays 0. A clk_good in the same cycle as that tick wins and no timeout occurs.
- R5: ready becomes 1 one clock after the SETTLE_TICKS-th tick counted in the settle period; a tick in the cycle that ends the wait is not counted.
- R6: A power-off request in any powered phase makes pll_en=0, phy_pd=1, otg_pd=1 and ready=0 one clock later; phy_rst is not changed.
- R7: A power-off request during the wait or settle period aborts it immediately: timed_out is not set and ready does not rise.
- R8: timed_out stays 1 through power-off and further ticks until the next accepted power-on request, and clears one clock after it.
- R9: When power-on and power-off are requested in the same cycle, power-off wins; a power-on request while already powered has no effect.
- R10: While powered down, tick and clk_good have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on_req | input | 1 | Single-cycle power-on request |
| pwr_off_req | input | 1 | Single-cycle power-off request |
| tick | input | 1 | Timebase clock-enable pulse |
| clk_good | input | 1 | PHY clock-stable indication |
| phy_rst | output | 1 | PHY reset control, active high |
| phy_pd | output | 1 | PHY power-down control |
| otg_pd | output | 1 | OTG comparator power-down control |
| pll_en | output | 1 | PHY PLL enable |
| ready | output | 1 | Sequence finished with a good clock |
| timed_out | output | 1 | Sticky: clock wait expired |

## Verification
A behavioural reference model runs beside the design and every output is compared each clock. The stimulus covers a normal power-up where clk_good arrives mid-wait, which separates the wait from the settle count; a power-up where clk_good never arrives, which exposes the timeout boundary at exactly the last tick; and clk_good arriving together with that last tick, which tells clock-good priority from timeout priority. Power-off is injected during the wait, during the settle period and after ready, and simultaneous on/off requests, repeated power-on while powered, and ticks while off show which requests are ignored.

// File: rtl/phy_pwr_seq_pkg.sv
package phy_pwr_seq_pkg;

  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_WAIT   = 2'd1,
    ST_SETTLE = 2'd2,
    ST_ON     = 2'd3
  } pwr_st_e;

  typedef struct packed {
    logic phy_pd;
    logic otg_pd;
    logic pll_en;
  } phy_ctl_t;

  function automatic phy_ctl_t ctl_for_state(pwr_st_e st);
    phy_ctl_t c;
    if (st == ST_OFF) begin
      c.phy_pd = 1'b1;
      c.otg_pd = 1'b1;
      c.pll_en = 1'b0;
    end else begin
      c.phy_pd = 1'b0;
      c.otg_pd = 1'b0;
      c.pll_en = 1'b1;
    end
    return c;
  endfunction

endpackage

// File: rtl/phy_pwr_seq_tmr.sv
module phy_pwr_seq_tmr #(
  parameter int WAIT_TICKS   = 100,
  parameter int SETTLE_TICKS = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  input  logic tick,
  output logic wait_hit,
  output logic settle_hit
);
  localparam int MAX_LIM = (WAIT_TICKS > SETTLE_TICKS) ? WAIT_TICKS : SETTLE_TICKS;
  localparam int CW      = $clog2(MAX_LIM + 1);
  localparam logic [CW-1:0] WAIT_LAST   = CW'(WAIT_TICKS - 1);
  localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_TICKS - 1);

  logic [CW-1:0] cnt;
  logic          step;

  assign step       = run && tick;
  assign wait_hit   = step && (cnt == WAIT_LAST);
  assign settle_hit = step && (cnt == SETTLE_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (step) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/phy_pwr_seq_fsm.sv
module phy_pwr_seq_fsm
  import phy_pwr_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    on_req,
  input  logic    off_req,
  input  logic    clk_good,
  input  logic    wait_hit,
  input  logic    settle_hit,
  output pwr_st_e st,
  output logic    cnt_run,
  output logic    cnt_clr,
  output logic    start,
  output logic    expire,
  output logic    good_seen
);
  pwr_st_e nxt;

  always_comb begin
    nxt    = st;
    start  = 1'b0;
    expire = 1'b0;
    unique case (st)
      ST_OFF: begin
        if (on_req && !off_req) begin
          nxt   = ST_WAIT;
          start = 1'b1;
        end
      end
      ST_WAIT: begin
        if (off_req) begin
          nxt = ST_OFF;
        end else if (clk_good) begin
          nxt = ST_SETTLE;
        end else if (wait_hit) begin
          nxt    = ST_SETTLE;
          expire = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (off_req)         nxt = ST_OFF;
        else if (settle_hit) nxt = ST_ON;
      end
      ST_ON: begin
        if (off_req) nxt = ST_OFF;
      end
      default: nxt = ST_OFF;
    endcase
  end

  assign cnt_run = (st == ST_WAIT) || (st == ST_SETTLE);
  assign cnt_clr = (nxt != st);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_OFF;
      good_seen <= 1'b0;
    end else begin
      st <= nxt;
      if (start)
        good_seen <= 1'b0;
      else if (st == ST_WAIT && !off_req && clk_good)
        good_seen <= 1'b1;
    end
  end

endmodule

// File: rtl/phy_pwr_seq_ctl.sv
module phy_pwr_seq_ctl
  import phy_pwr_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  pwr_st_e st,
  input  logic    start,
  input  logic    expire,
  input  logic    good_seen,
  output logic    phy_rst,
  output logic    phy_pd,
  output logic    otg_pd,
  output logic    pll_en,
  output logic    ready,
  output logic    timed_out
);
  phy_ctl_t ctl;

  assign ctl    = ctl_for_state(st);
  assign phy_pd = ctl.phy_pd;
  assign otg_pd = ctl.otg_pd;
  assign pll_en = ctl.pll_en;
  assign ready  = (st == ST_ON) && good_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phy_rst   <= 1'b1;
      timed_out <= 1'b0;
    end else begin
      if (start) phy_rst <= 1'b0;
      if (start)       timed_out <= 1'b0;
      else if (expire) timed_out <= 1'b1;
    end
  end

endmodule

// File: rtl/phy_pwr_seq.sv
module phy_pwr_seq
  import phy_pwr_seq_pkg::*;
#(
  parameter int WAIT_TICKS   = 100,
  parameter int SETTLE_TICKS = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_on_req,
  input  logic pwr_off_req,
  input  logic tick,
  input  logic clk_good,
  output logic phy_rst,
  output logic phy_pd,
  output logic otg_pd,
  output logic pll_en,
  output logic ready,
  output logic timed_out
);
  pwr_st_e st;
  logic    cnt_run, cnt_clr, start, expire, good_seen;
  logic    wait_hit, settle_hit;

  phy_pwr_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .on_req     (pwr_on_req),
    .off_req    (pwr_off_req),
    .clk_good   (clk_good),
    .wait_hit   (wait_hit),
    .settle_hit (settle_hit),
    .st         (st),
    .cnt_run    (cnt_run),
    .cnt_clr    (cnt_clr),
    .start      (start),
    .expire     (expire),
    .good_seen  (good_seen)
  );

  phy_pwr_seq_tmr #(
    .WAIT_TICKS   (WAIT_TICKS),
    .SETTLE_TICKS (SETTLE_TICKS)
  ) u_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (cnt_run),
    .clr        (cnt_clr),
    .tick       (tick),
    .wait_hit   (wait_hit),
    .settle_hit (settle_hit)
  );

  phy_pwr_seq_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (st),
    .start     (start),
    .expire    (expire),
    .good_seen (good_seen),
    .phy_rst   (phy_rst),
    .phy_pd    (phy_pd),
    .otg_pd    (otg_pd),
    .pll_en    (pll_en),
    .ready     (ready),
    .timed_out (timed_out)
  );

endmodule

// File: rtl/phy_pwr_seq_chk.sv
module phy_pwr_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic pwr_on_req,
  input logic pwr_off_req,
  input logic tick,
  input logic clk_good,
  input logic phy_rst,
  input logic phy_pd,
  input logic otg_pd,
  input logic pll_en,
  input logic ready,
  input logic timed_out
);

  // R1
  rst_stays_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !phy_rst |=> !phy_rst);

  // R2
  power_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pll_en && pwr_on_req && !pwr_off_req) |=>
      (pll_en && !phy_pd && !otg_pd && !phy_rst && !timed_out));

  // R6
  power_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_off_req |=> (!pll_en && phy_pd && otg_pd && !ready));

  // R3
  ready_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (pll_en && !timed_out && !phy_pd && !otg_pd));

  // R4
  timeout_powered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timed_out) |-> (pll_en && !ready));

  // R8
  timeout_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(timed_out) |-> $past(pwr_on_req));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pll_en && !pwr_on_req) |=> (!pll_en && phy_pd && $stable(timed_out)));

  // R1
  always_comb begin
    if (rst_n) begin
      ctl_pair_chk: assert (phy_pd == otg_pd);
    end
  end

  logic unused_in;
  assign unused_in = tick ^ clk_good;

endmodule

bind phy_pwr_seq phy_pwr_seq_chk u_chk (.*);

// File: tb/phy_pwr_seq_bench.sv
module phy_pwr_seq_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int W = 8;
  localparam int S = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_on_req = 1'b0, pwr_off_req = 1'b0, tick = 1'b0, clk_good = 1'b0;
  logic phy_rst, phy_pd, otg_pd, pll_en, ready, timed_out;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  phy_pwr_seq #(.WAIT_TICKS(W), .SETTLE_TICKS(S)) u_phy_pwr_seq (
    .clk(clk), .rst_n(rst_n), .pwr_on_req(pwr_on_req), .pwr_off_req(pwr_off_req),
    .tick(tick), .clk_good(clk_good), .phy_rst(phy_rst), .phy_pd(phy_pd),
    .otg_pd(otg_pd), .pll_en(pll_en), .ready(ready), .timed_out(timed_out)
  );

  // Reference model: phase 0 off, 1 waiting, 2 settling, 3 on
  int m_ph = 0;
  int m_ticks = 0;
  bit m_rst = 1, m_to = 0, m_good = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_ticks = 0; m_rst = 1; m_to = 0; m_good = 0;
    end else if (m_ph == 0) begin
      if (pwr_on_req && !pwr_off_req) begin
        m_ph = 1; m_ticks = 0; m_rst = 0; m_to = 0; m_good = 0;
      end
    end else if (pwr_off_req) begin
      m_ph = 0; m_ticks = 0;
    end else if (m_ph == 1) begin
      if (clk_good) begin
        m_ph = 2; m_ticks = 0; m_good = 1;
      end else if (tick) begin
        m_ticks++;
        if (m_ticks == W) begin
          m_ph = 2; m_ticks = 0; m_to = 1;
        end
      end
    end else if (m_ph == 2) begin
      if (tick) begin
        m_ticks++;
        if (m_ticks == S) begin
          m_ph = 3; m_ticks = 0;
        end
      end
    end
  end

  task automatic cmp(string tag, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && !done) begin
      cmp("R1 phy_rst", phy_rst, m_rst);
      cmp("R2/R6 phy_pd", phy_pd, m_ph == 0);
      cmp("R2/R6 otg_pd", otg_pd, m_ph == 0);
      cmp("R2/R6 pll_en", pll_en, m_ph != 0);
      cmp("R3/R5 ready", ready, (m_ph == 3) && m_good);
      cmp("R4/R8 timed_out", timed_out, m_to);
    end
    if (cyc > 100000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_on();
    pwr_on_req = 1'b1; @(negedge clk); pwr_on_req = 1'b0;
  endtask

  task automatic pulse_off();
    pwr_off_req = 1'b1; @(negedge clk); pwr_off_req = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; @(negedge clk); tick = 1'b0; @(negedge clk);
    end
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    cmp("R1 reset phy_rst", phy_rst, 1'b1);
    cmp("R1 reset pll_en", pll_en, 1'b0);
    cmp("R1 reset ready", ready, 1'b0);

    // R10 ticks and clk_good while off
    clk_good = 1'b1;
    ticks(W + 2);
    cmp("R10 off pll_en", pll_en, 1'b0);
    cmp("R10 off timed_out", timed_out, 1'b0);
    clk_good = 1'b0;

    // R2 power up
    pulse_on();
    cmp("R2 pll_en", pll_en, 1'b1);
    cmp("R2 phy_rst", phy_rst, 1'b0);
    cmp("R2 phy_pd", phy_pd, 1'b0);

    // R3 / R5 good clock mid-wait, then settle count
    ticks(3);
    tick = 1'b1; clk_good = 1'b1; @(negedge clk); tick = 1'b0;
    ticks(S - 1);
    cmp("R5 not yet ready", ready, 1'b0);
    ticks(1);
    cmp("R5 ready after settle", ready, 1'b1);
    clk_good = 1'b0;

    // R9 on while powered ignored; simultaneous on/off -> off
    pulse_on();
    cmp("R9 repeat on keeps ready", ready, 1'b1);
    pwr_on_req = 1'b1; pwr_off_req = 1'b1; @(negedge clk);
    pwr_on_req = 1'b0; pwr_off_req = 1'b0;
    cmp("R9 off wins pll_en", pll_en, 1'b0);
    cmp("R6 off phy_pd", phy_pd, 1'b1);
    cmp("R6 off phy_rst unchanged", phy_rst, 1'b0);

    // R4 timeout path
    pulse_on();
    ticks(W - 1);
    cmp("R4 before limit", timed_out, 1'b0);
    ticks(1);
    cmp("R4 timed out", timed_out, 1'b1);
    cmp("R4 still powered", pll_en, 1'b1);
    ticks(S + 1);
    cmp("R4 no ready", ready, 1'b0);

    // R8 sticky through off, cleared by on
    pulse_off();
    ticks(2);
    cmp("R8 sticky after off", timed_out, 1'b1);
    pulse_on();
    cmp("R8 cleared by on", timed_out, 1'b0);

    // R7 abort during wait
    ticks(W - 1);
    pulse_off();
    cmp("R7 wait abort pll_en", pll_en, 1'b0);
    ticks(2);
    cmp("R7 no timeout", timed_out, 1'b0);

    // R7 abort during settle
    pulse_on();
    clk_good = 1'b1; @(negedge clk); clk_good = 1'b0;
    ticks(S - 1);
    pulse_off();
    ticks(2);
    cmp("R7 settle abort ready", ready, 1'b0);

    // R4 clk_good wins over last tick
    pulse_on();
    ticks(W - 1);
    tick = 1'b1; clk_good = 1'b1; @(negedge clk); tick = 1'b0; clk_good = 1'b0;
    cmp("R4 tie no timeout", timed_out, 1'b0);
    ticks(S);
    cmp("R4 tie ready", ready, 1'b1);

    // R6 off after ready
    pulse_off();
    cmp("R6 ready drops", ready, 1'b0);
    cmp("R6 otg_pd", otg_pd, 1'b1);
    idle(3);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule